// File: doc/BRIEF.md
# UART FIFO Control and Receive Threshold

This block holds the FIFO control settings of a UART and turns the receive FIFO fill level into two service signals. Software writes an 8-bit control byte at an address it shares with a read-only identification register. The bus decode sends writes here and sends reads to the identification logic, so the block has a write strobe and no read path. Each write does four things. It sets the FIFO enable. It fires one-cycle clear pulses at the receive and transmit FIFOs. It selects the transmit interrupt level. It stores a 2-bit receive trigger level.

The trigger level picks a receive threshold of 1, 8, 16 or 32 bytes. The occupancy count of the 64-entry receive FIFO is compared against that threshold in the same cycle. When the count is at or above the threshold, the block raises a receive-data-available interrupt condition, gated by its enable bit. In DMA mode it also raises a receive DMA request, except when the 1-byte level is selected, because that level is not valid for DMA.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset, `fifo_en`, `tx_lvl_sel`, `rx_clr`, `tx_clr`, `rx_irq` and `rx_dma_req` are 0, and `rx_trig_lvl` is 2'b00.
- R2: A write with `wr_en` high loads bit 0 into `fifo_en`, bit 3 into `tx_lvl_sel` and bits 7:6 into `rx_trig_lvl`. The new values appear in the cycle after the write edge. Without a write, these outputs hold their values.
- R3: A write with bit 1 set drives `rx_clr` high for exactly the one cycle after the write edge. A write with bit 2 set does the same for `tx_clr`. Neither bit is stored.
- R4: The trigger level maps to a threshold as follows: 2'b00 gives 1 byte, 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 32.
- R5: `rx_irq` is high exactly when `rx_irq_en` is 1 and `rx_count` is greater than or equal to the threshold. It depends combinationally on the stored level and the current count.
- R6: `rx_dma_req` is high exactly when `dma_mode` is 1, `rx_trig_lvl` is not 2'b00, and `rx_count` is greater than or equal to the threshold.
- R7: Bits 5:4 of the write data have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control byte being written |
| rx_count | input | 7 | Receive FIFO occupancy, 0 to 64 |
| rx_irq_en | input | 1 | Receive-data-available interrupt enable |
| dma_mode | input | 1 | DMA mode is selected |
| fifo_en | output | 1 | Transmit and receive FIFOs enabled |
| rx_clr | output | 1 | One-cycle receive FIFO clear pulse |
| tx_clr | output | 1 | One-cycle transmit FIFO clear pulse |
| tx_lvl_sel | output | 1 | Transmit interrupt level select |
| rx_trig_lvl | output | 2 | Stored receive trigger level |
| rx_irq | output | 1 | Receive-data-available interrupt condition |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
Register fields and clear pulses come from flops, so they are due one cycle after the write edge. The bench drives each write on a falling edge and samples at the next falling edge, which is exactly one cycle later. It samples once more a cycle after that to confirm that each pulse has dropped. The interrupt and DMA outputs are combinational on the stored level and the live count, so the bench sets the count on a falling edge and samples after a short settle in the same low phase. The sweep covers every level, every count from 0 to 64, and every combination of interrupt enable and DMA mode.

// File: rtl/uart_fcr_pkg.sv
package uart_fcr_pkg;
  localparam int CTRL_W     = 8;
  localparam int BIT_FEN    = 0;
  localparam int BIT_RXCLR  = 1;
  localparam int BIT_TXCLR  = 2;
  localparam int BIT_TXLVL  = 3;
  localparam int LVL_LSB    = 6;
  localparam int LVL_W      = 2;

  typedef enum logic [LVL_W-1:0] {
    TRIG_1  = 2'b00,
    TRIG_8  = 2'b01,
    TRIG_16 = 2'b10,
    TRIG_32 = 2'b11
  } trig_lvl_e;

  typedef struct packed {
    logic      fen;
    logic      txlvl;
    trig_lvl_e lvl;
  } ctrl_t;
endpackage

// File: rtl/uart_fcr_regs.sv
module uart_fcr_regs
  import uart_fcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic              rx_clr,
  output logic              tx_clr
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.fen   = wr_data[BIT_FEN];
      ctrl_d.txlvl = wr_data[BIT_TXLVL];
      ctrl_d.lvl   = trig_lvl_e'(wr_data[LVL_LSB +: LVL_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{fen: 1'b0, txlvl: 1'b0, lvl: TRIG_1};
      rx_clr <= 1'b0;
      tx_clr <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      rx_clr <= wr_en & wr_data[BIT_RXCLR];
      tx_clr <= wr_en & wr_data[BIT_TXCLR];
    end
  end

  assign ctrl = ctrl_q;
endmodule

// File: rtl/uart_rx_trig.sv
module uart_rx_trig
  import uart_fcr_pkg::*;
#(
  parameter int CNT_W = 7
)(
  input  trig_lvl_e        lvl,
  input  logic [CNT_W-1:0] count,
  input  logic             irq_en,
  input  logic             dma_mode,
  output logic             irq,
  output logic             dma_req
);
  localparam int BASE_SH = 2;

  logic [CNT_W-1:0] thresh;
  logic             reached;

  always_comb begin
    if (lvl == TRIG_1) thresh = CNT_W'(1);
    else               thresh = CNT_W'(1) << (BASE_SH + int'(lvl));
  end

  assign reached = (count >= thresh);
  assign irq     = irq_en & reached;
  assign dma_req = dma_mode & (lvl != TRIG_1) & reached;
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fcr_pkg::*;
#(
  parameter int FIFO_DEPTH = 64,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic              rx_irq_en,
  input  logic              dma_mode,
  output logic              fifo_en,
  output logic              rx_clr,
  output logic              tx_clr,
  output logic              tx_lvl_sel,
  output logic [LVL_W-1:0]  rx_trig_lvl,
  output logic              rx_irq,
  output logic              rx_dma_req
);
  ctrl_t ctrl;

  uart_fcr_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctrl    (ctrl),
    .rx_clr  (rx_clr),
    .tx_clr  (tx_clr)
  );

  uart_rx_trig #(.CNT_W(CNT_W)) u_trig (
    .lvl      (ctrl.lvl),
    .count    (rx_count),
    .irq_en   (rx_irq_en),
    .dma_mode (dma_mode),
    .irq      (rx_irq),
    .dma_req  (rx_dma_req)
  );

  assign fifo_en     = ctrl.fen;
  assign tx_lvl_sel  = ctrl.txlvl;
  assign rx_trig_lvl = ctrl.lvl;
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk
  import uart_fcr_pkg::*;
#(
  parameter int CNT_W = 7
)(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic [CNT_W-1:0]  rx_count,
  input logic              rx_irq_en,
  input logic              dma_mode,
  input logic              rx_clr,
  input logic              tx_clr,
  input logic [LVL_W-1:0]  rx_trig_lvl,
  input logic              rx_irq,
  input logic              rx_dma_req
);
  // R2
  lvl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rx_trig_lvl == $past(wr_data[LVL_LSB +: LVL_W]));

  // R2
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rx_trig_lvl));

  // R3
  rx_clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[BIT_RXCLR]) |=> rx_clr);

  // R3
  rx_clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[BIT_RXCLR]) |=> !rx_clr);

  // R3
  tx_clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_data[BIT_TXCLR]) |=> !tx_clr);

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_irq_en);

  // R6
  dma_lvl1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_trig_lvl == 2'b00) |-> !rx_dma_req);

  // R6
  dma_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == '0 || !dma_mode) |-> !rx_dma_req);
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rx_count    (rx_count),
  .rx_irq_en   (rx_irq_en),
  .dma_mode    (dma_mode),
  .rx_clr      (rx_clr),
  .tx_clr      (tx_clr),
  .rx_trig_lvl (rx_trig_lvl),
  .rx_irq      (rx_irq),
  .rx_dma_req  (rx_dma_req)
);

// File: tb/uart_fifo_ctl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [6:0] rx_count = '0;
  logic       rx_irq_en = 1'b0;
  logic       dma_mode = 1'b0;
  logic       fifo_en, rx_clr, tx_clr, tx_lvl_sel, rx_irq, rx_dma_req;
  logic [1:0] rx_trig_lvl;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  uart_fifo_ctl u_uart_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rx_count(rx_count), .rx_irq_en(rx_irq_en), .dma_mode(dma_mode),
    .fifo_en(fifo_en), .rx_clr(rx_clr), .tx_clr(tx_clr),
    .tx_lvl_sel(tx_lvl_sel), .rx_trig_lvl(rx_trig_lvl),
    .rx_irq(rx_irq), .rx_dma_req(rx_dma_req)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int thr_of(int lvl);
    return (lvl == 0) ? 1 : (4 << lvl);
  endfunction

  // drive write on falling edge; returns at next falling edge (one cycle later)
  task automatic do_write(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 fifo_en", fifo_en, 0);
    chk("R1 tx_lvl_sel", tx_lvl_sel, 0);
    chk("R1 rx_clr", rx_clr, 0);
    chk("R1 tx_clr", tx_clr, 0);
    chk("R1 rx_trig_lvl", rx_trig_lvl, 0);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 rx_dma_req", rx_dma_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 field loads, R3 pulses, across all byte values with reserved bits 5:4 = 0
    for (int v = 0; v < 256; v++) begin
      logic [7:0] d;
      d = 8'(v) & 8'hCF;
      do_write(d);
      chk("R2 fifo_en", fifo_en, d[0]);
      chk("R2 tx_lvl_sel", tx_lvl_sel, d[3]);
      chk("R2 rx_trig_lvl", rx_trig_lvl, d[7:6]);
      chk("R3 rx_clr pulse", rx_clr, d[1]);
      chk("R3 tx_clr pulse", tx_clr, d[2]);
      @(negedge clk);
      chk("R3 rx_clr drops", rx_clr, 0);
      chk("R3 tx_clr drops", tx_clr, 0);
      chk("R2 hold lvl", rx_trig_lvl, d[7:6]);
      chk("R2 hold fen", fifo_en, d[0]);
    end

    // R7 reserved bits 5:4 have no effect
    for (int r = 1; r < 4; r++) begin
      logic [7:0] d;
      d = 8'h89 | 8'(r << 4);
      do_write(d);
      chk("R7 fifo_en", fifo_en, 1);
      chk("R7 tx_lvl_sel", tx_lvl_sel, 1);
      chk("R7 rx_trig_lvl", rx_trig_lvl, 2);
      chk("R7 rx_clr", rx_clr, 0);
      chk("R7 tx_clr", tx_clr, 0);
    end

    // R4 R5 R6 sweep of levels, counts, enables
    for (int lvl = 0; lvl < 4; lvl++) begin
      do_write(8'(lvl << 6) | 8'h01);
      chk("R2 lvl before sweep", rx_trig_lvl, lvl);
      for (int c = 0; c <= 64; c++) begin
        for (int m = 0; m < 4; m++) begin
          rx_count = 7'(c); rx_irq_en = m[0]; dma_mode = m[1];
          #0.5;
          chk("R4 R5 rx_irq", rx_irq, (m[0] && c >= thr_of(lvl)) ? 1 : 0);
          chk("R4 R6 rx_dma_req", rx_dma_req,
              (m[1] && lvl != 0 && c >= thr_of(lvl)) ? 1 : 0);
        end
      end
    end

    // R5 level change effect lands one cycle after the write edge
    rx_count = 7'd10; rx_irq_en = 1'b1; dma_mode = 1'b1;
    do_write(8'h40);
    chk("R5 level 8 count 10 irq", rx_irq, 1);
    chk("R6 level 8 count 10 dma", rx_dma_req, 1);
    do_write(8'hC0);
    chk("R5 level 32 count 10 irq", rx_irq, 0);
    chk("R6 level 32 count 10 dma", rx_dma_req, 0);
    do_write(8'h00);
    chk("R5 level 1 count 10 irq", rx_irq, 1);
    chk("R6 level 1 no dma", rx_dma_req, 0);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule